// File: doc/BRIEF.md
# ECC Event Status Logger

This block collects error-correction events seen on the read path of a flash memory. Each of its bus ports, by default an instruction-fetch port and a data port, delivers one strobe per read that needed a single-bit correction and another per read that hit an uncorrectable double-bit error. The block turns these strobes into a status word that software reads and clears by writing ones. The word holds a 2-bit code per port, a saturating count of repeated corrections, a sticky interrupt-cause field, and a flag for command requests that arrived while a command was still running.

Two mask inputs decide which event classes may raise the interrupt. The per-port codes record every event whatever the masks say. Only enabled events reach the cause field, the interrupt line and the correction counter. A command request made while the busy input is high is dropped and flagged. A request made while idle is accepted and shown by a one-cycle pulse.

Top module: `ecc_evt_logger`

## Requirements
- R1: Each port p owns status bits [2p+1:2p], coded 00 = nothing, 01 = double-bit error, 10 = single-bit correction. The value 11 never appears. With two ports, port 0 is bits [1:0] and port 1 is bits [3:2].
- R2: A double-bit strobe sets its port code to 01. A correction strobe sets it to 10 unless it already holds 01, in which case it stays 01. The codes update whatever the masks say, and each port updates on its own.
- R3: A register write clears every port-code bit whose write-data bit is one. Writing one to a bit that is zero changes nothing. If an event sets a bit in the same cycle as a write clears it, the bit stays set.
- R4: The counter in bits [6:4] goes up by one in a cycle where the correction mask is on, at least one port gives a correction strobe, and cause bit 8 was already set before that cycle. It goes up by at most one per cycle, however many ports report.
- R5: The counter holds at 7 and does not wrap.
- R6: The counter goes to 0 on any write with a one in bits [3:0] or bits [6:4]. When such a write and an increment fall in the same cycle, the clear wins.
- R7: Cause bit 7 is set by a double-bit strobe from any port while the double-bit mask is on. Cause bit 8 is set by a correction strobe while the correction mask is on. Both bits are sticky and cleared by writing one, and a new event wins over a clear in the same cycle.
- R8: The registered output irq is high when (cause bit 7 and the double-bit mask) or (cause bit 8 and the correction mask) is true, using the cause value just written. It drops when the cause is cleared or the matching mask is turned off.
- R9: A command request made while busy is high sets bit 9 and is dropped. Bit 9 is cleared by writing one. A request made while busy is low gives a one-cycle pulse on cmd_accept on the next cycle.
- R10: A synchronous reset clears the status word, irq and cmd_accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_evt | input | NPORTS (2) | Single-bit correction strobe per port |
| ded_evt | input | NPORTS (2) | Double-bit error strobe per port |
| en_sec | input | 1 | Correction interrupt mask |
| en_ded | input | 1 | Double-bit interrupt mask |
| cmd_req | input | 1 | Command request |
| cmd_busy | input | 1 | A command is running |
| cmd_accept | output | 1 | Accepted-request pulse |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | STAT_W (10) | Write-one-to-clear mask |
| rd_data | output | STAT_W (10) | Status word |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets the ordering corners. A design that lets a correction overwrite a recorded double-bit error loses the more serious code. One that counts the first correction, or counts once per port in the same cycle, reports too many repeats. One that wraps the counter shows a small count after many corrections. It also sends an event in the same cycle as a clear of the same bit, where a design that lets the clear win would lose that event. It also checks that a masked event leaves the cause and irq alone while the port code is still recorded, and that a request made while busy is flagged and never accepted.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_DED  = 2'b01,
    ST_SEC  = 2'b10
  } ecc_st_e;
endpackage

// File: rtl/ecc_port_field.sv
`timescale 1ns/1ps
// One port's 2-bit status code: double-bit wins, no downgrade, event beats clear.
module ecc_port_field
  import ecc_log_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sec,
  input  logic       ded,
  input  logic [1:0] clr_mask,
  output logic [1:0] field
);
  logic [1:0] kept;
  logic [1:0] nxt;

  always_comb begin
    kept = field & ~clr_mask;
    if (ded)
      nxt = ST_DED;
    else if (sec && kept != ST_DED)
      nxt = ST_SEC;
    else
      nxt = kept;
  end

  always_ff @(posedge clk) begin
    if (rst) field <= ST_NONE;
    else     field <= nxt;
  end
endmodule

// File: rtl/ecc_sat_counter.sv
`timescale 1ns/1ps
// Saturating counter; clear has priority over increment.
module ecc_sat_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/ecc_w1c_bits.sv
`timescale 1ns/1ps
// Sticky bits, cleared by ones, set wins. Next value exported for registered outputs.
module ecc_w1c_bits #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] bits,
  output logic [W-1:0] bits_nxt
);
  assign bits_nxt = (bits & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else     bits <= bits_nxt;
  end
endmodule

// File: rtl/ecc_evt_logger.sv
`timescale 1ns/1ps
module ecc_evt_logger #(
  parameter  int NPORTS = 2,
  parameter  int CNT_W  = 3,
  localparam int STAT_W = 2*NPORTS + CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] sec_evt,
  input  logic [NPORTS-1:0] ded_evt,
  input  logic              en_sec,
  input  logic              en_ded,
  input  logic              cmd_req,
  input  logic              cmd_busy,
  output logic              cmd_accept,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);
  localparam int FLD_W    = 2*NPORTS;
  localparam int CNT_LO   = FLD_W;
  localparam int CAUSE_LO = FLD_W + CNT_W;
  localparam int OVL_BIT  = CAUSE_LO + 2;

  logic [STAT_W-1:0] wmask;
  logic [FLD_W-1:0]  fld;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        cause;
  logic [1:0]        cause_n;
  logic              ovl;
  logic              any_sec;
  logic              any_ded;
  logic              cnt_inc;
  logic              cnt_clr;

  assign wmask   = reg_wr ? reg_wdata : '0;
  assign any_sec = |sec_evt;
  assign any_ded = |ded_evt;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ecc_port_field u_fld (
      .clk      (clk),
      .rst      (rst),
      .sec      (sec_evt[p]),
      .ded      (ded_evt[p]),
      .clr_mask (wmask[2*p +: 2]),
      .field    (fld[2*p +: 2])
    );
  end

  ecc_w1c_bits #(.W(2)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .set      ({any_sec & en_sec, any_ded & en_ded}),
    .clr      (wmask[CAUSE_LO +: 2]),
    .bits     (cause),
    .bits_nxt (cause_n)
  );

  // repeat corrections only: cause bit for corrections must already be set
  assign cnt_inc = en_sec & any_sec & cause[1];
  assign cnt_clr = (|wmask[FLD_W-1:0]) | (|wmask[CNT_LO +: CNT_W]);

  ecc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (cnt_inc),
    .clr (cnt_clr),
    .cnt (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl        <= 1'b0;
      cmd_accept <= 1'b0;
      irq        <= 1'b0;
    end else begin
      ovl        <= (ovl & ~wmask[OVL_BIT]) | (cmd_req & cmd_busy);
      cmd_accept <= cmd_req & ~cmd_busy;
      irq        <= |(cause_n & {en_sec, en_ded});
    end
  end

  assign rd_data = {ovl, cause, cnt, fld};
endmodule

// File: rtl/ecc_evt_logger_chk.sv
`timescale 1ns/1ps
module ecc_evt_logger_chk #(
  parameter  int NPORTS = 2,
  parameter  int CNT_W  = 3,
  localparam int STAT_W = 2*NPORTS + CNT_W + 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_req,
  input logic              cmd_busy,
  input logic              cmd_accept,
  input logic              reg_wr,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] rd_data,
  input logic              irq
);
  localparam int FLD_W    = 2*NPORTS;
  localparam int CNT_LO   = FLD_W;
  localparam int CAUSE_LO = FLD_W + CNT_W;
  localparam int OVL_BIT  = CAUSE_LO + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [1:0]       cause;
  logic             ovl;
  logic             clr_w;

  assign cnt   = rd_data[CNT_LO +: CNT_W];
  assign cause = rd_data[CAUSE_LO +: 2];
  assign ovl   = rd_data[OVL_BIT];
  assign clr_w = reg_wr && ((|reg_wdata[FLD_W-1:0]) || (|reg_wdata[CNT_LO +: CNT_W]));

  for (genvar p = 0; p < NPORTS; p++) begin : g_fld
    // R1
    fld_legal_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[2*p +: 2] != 2'b11);
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_w |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr_w) |=> cnt == CNT_MAX);

  // R6
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> cnt == '0);

  for (genvar b = 0; b < 2; b++) begin : g_cause
    // R7
    cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (cause[b] && !(reg_wr && reg_wdata[CAUSE_LO+b])) |=> cause[b]);
  end

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> cause != 2'b00);

  // R9
  ovl_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_req && cmd_busy) |=> ovl);

  // R9
  ovl_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[OVL_BIT] && !(cmd_req && cmd_busy)) |=> !ovl);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |=> !cmd_accept);
endmodule

bind ecc_evt_logger ecc_evt_logger_chk #(.NPORTS(NPORTS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_req    (cmd_req),
  .cmd_busy   (cmd_busy),
  .cmd_accept (cmd_accept),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .rd_data    (rd_data),
  .irq        (irq)
);

// File: tb/test_ecc_evt_logger.sv
`timescale 1ns/1ps
module test_ecc_evt_logger;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sec_evt = '0;
  logic [1:0] ded_evt = '0;
  logic       en_sec = 1'b1;
  logic       en_ded = 1'b1;
  logic       cmd_req = 1'b0;
  logic       cmd_busy = 1'b0;
  logic       cmd_accept;
  logic       reg_wr = 1'b0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] rd_data;
  logic       irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ecc_evt_logger i_ecc_evt_logger (
    .clk(clk), .rst(rst), .sec_evt(sec_evt), .ded_evt(ded_evt),
    .en_sec(en_sec), .en_ded(en_ded), .cmd_req(cmd_req), .cmd_busy(cmd_busy),
    .cmd_accept(cmd_accept), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] m);
    reg_wr = 1'b1; reg_wdata = m;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [1:0] s, input logic [1:0] d);
    sec_evt = s; ded_evt = d;
    tick();
    sec_evt = '0; ded_evt = '0;
  endtask

  function automatic int f0();    return int'(rd_data[1:0]); endfunction
  function automatic int f1();    return int'(rd_data[3:2]); endfunction
  function automatic int cnt();   return int'(rd_data[6:4]); endfunction
  function automatic int cause(); return int'(rd_data[8:7]); endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R10 status after reset", int'(rd_data), 0);
    chk("R10 irq after reset", int'(irq), 0);
    chk("R10 accept after reset", int'(cmd_accept), 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_first_sec();
    wr(10'h3FF);
    pulse(2'b01, 2'b00);
    chk("R1 port0 code after correction", f0(), 2);
    chk("R4 first correction not counted", cnt(), 0);
    chk("R7 cause after correction", cause(), 2);
    chk("R8 irq after enabled correction", int'(irq), 1);
    pulse(2'b10, 2'b00);
    chk("R2 port1 code", f1(), 2);
    chk("R4 repeat correction counted", cnt(), 1);
  endtask

  task automatic t_saturate();
    wr(10'h3FF);
    pulse(2'b01, 2'b00);
    for (int i = 0; i < 9; i++) pulse(2'b01, 2'b00);
    chk("R5 counter holds at 7", cnt(), 7);
  endtask

  task automatic t_port_clear();
    wr(10'h3FF);
    pulse(2'b01, 2'b00);
    pulse(2'b10, 2'b00);
    pulse(2'b00, 2'b10);
    chk("R2 port1 double-bit overrides", f1(), 1);
    chk("R7 both causes", cause(), 3);
    chk("R4 double-bit not counted", cnt(), 1);
    wr(10'h002);
    chk("R3 port0 cleared", f0(), 0);
    chk("R3 port1 untouched", f1(), 1);
    chk("R6 counter cleared by port clear", cnt(), 0);
    chk("R7 cause untouched by port clear", cause(), 3);
    wr(10'h008);
    chk("R3 one to zero bit no effect", f1(), 1);
  endtask

  task automatic t_ded_override();
    wr(10'h3FF);
    pulse(2'b01, 2'b00);
    pulse(2'b00, 2'b01);
    chk("R2 double-bit replaces correction", f0(), 1);
    pulse(2'b01, 2'b00);
    chk("R2 correction does not downgrade", f0(), 1);
    chk("R7 cause both", cause(), 3);
    wr(10'h180);
    chk("R7 cause cleared", cause(), 0);
    chk("R8 irq drops with cause", int'(irq), 0);
    chk("R3 port code kept on cause clear", f0(), 1);
  endtask

  task automatic t_disabled();
    wr(10'h3FF);
    en_sec = 1'b0; en_ded = 1'b0;
    pulse(2'b01, 2'b00);
    chk("R2 masked correction still recorded", f0(), 2);
    chk("R7 masked correction no cause", cause(), 0);
    chk("R8 masked correction no irq", int'(irq), 0);
    pulse(2'b00, 2'b10);
    chk("R2 masked double-bit recorded", f1(), 1);
    chk("R7 masked double-bit no cause", cause(), 0);
    chk("R4 masked no count", cnt(), 0);
    en_sec = 1'b1; en_ded = 1'b1;
  endtask

  task automatic t_enable_qualify();
    wr(10'h3FF);
    tick();
    pulse(2'b00, 2'b01);
    chk("R8 irq on double-bit", int'(irq), 1);
    en_ded = 1'b0;
    tick();
    chk("R8 irq off when mask off", int'(irq), 0);
    chk("R7 cause kept when mask off", cause(), 1);
    en_ded = 1'b1;
    tick();
    chk("R8 irq back with mask", int'(irq), 1);
  endtask

  task automatic t_both_ports();
    wr(10'h3FF);
    pulse(2'b01, 2'b00);
    pulse(2'b11, 2'b00);
    chk("R4 at most one per cycle", cnt(), 1);
    chk("R2 port0 same cycle", f0(), 2);
    chk("R2 port1 same cycle", f1(), 2);
  endtask

  task automatic t_race();
    wr(10'h3FF);
    pulse(2'b01, 2'b00);
    reg_wr = 1'b1; reg_wdata = 10'h102; sec_evt = 2'b01;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; sec_evt = '0;
    chk("R3 event beats clear", f0(), 2);
    chk("R7 cause event beats clear", cause(), 2);
    chk("R6 clear beats increment", cnt(), 0);
  endtask

  task automatic t_overlap();
    wr(10'h3FF);
    cmd_req = 1'b1; cmd_busy = 1'b1;
    tick();
    chk("R9 overlap set", int'(rd_data[9]), 1);
    chk("R9 busy request dropped", int'(cmd_accept), 0);
    cmd_busy = 1'b0;
    tick();
    chk("R9 idle request accepted", int'(cmd_accept), 1);
    cmd_req = 1'b0;
    tick();
    chk("R9 accept one cycle", int'(cmd_accept), 0);
    chk("R9 overlap sticky", int'(rd_data[9]), 1);
    wr(10'h200);
    chk("R9 overlap cleared", int'(rd_data[9]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_sec();
    t_saturate();
    t_port_clear();
    t_ded_override();
    t_disabled();
    t_enable_qualify();
    t_both_ports();
    t_race();
    t_overlap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule